// File: doc/BRIEF.md
# Windowed Strobe Supervisor with Fault Latch

This block supervises a processor that has to prove it is alive by toggling a strobe line once per program loop. Each falling edge of the strobe closes one measurement interval and opens the next. A falling edge that comes sooner than the lower bound shows that the program skipped part of its work. Silence that lasts up to the upper bound shows that the program is stuck. Either condition is a fault.

The first fault is captured in a latch, together with its cause. From then on the block drives an interrupt toward the processor and a disable line toward the stages that generate output. Both stay high until a synchronous reset. More strobes cannot clear the fault, and neither can the passage of time. The strobe is asynchronous and passes through a two-flop synchronizer first. Time is counted in ticks, which an internal prescaler derives from the system clock. Both window bounds are parameters given in ticks; with the default settings a tick is 1 ms.

Top module: `strobe_window_guard`

## Requirements
- R1: While reset is high, and in the cycle after it, `irq_o` and `disable_o` are 0 and `cause_o` is 2'b00. A reset clears a latched fault.
- R2: Only falling strobe edges count. A falling edge of `strobe_i` captured at clock edge k is acted on at edge k+2. Rising edges have no effect on the interval.
- R3: Clock edge s is the edge that starts an interval. If an accepted falling edge is acted on at edge s+d with d <= MIN_TICKS*CLK_PER_TICK, the fault latches at that edge with `cause_o` = 2'b01 (early).
- R4: If the falling edge is acted on with MIN_TICKS*CLK_PER_TICK < d <= MAX_TICKS*CLK_PER_TICK, no fault is raised and a new interval starts at that edge.
- R5: If no falling edge has been acted on by edge s+MAX_TICKS*CLK_PER_TICK, the fault latches at that edge with `cause_o` = 2'b10 (late). A falling edge acted on at that same edge wins, and counts as valid.
- R6: Once a fault is latched, `irq_o` and `cause_o` hold their values until reset, whatever the strobe does and however much time passes. The first cause is kept.
- R7: `irq_o` and `disable_o` are registered, level-high, and equal in every cycle. They are 1 exactly when `cause_o` is not 2'b00.
- R8: The first interval starts at the last reset edge. The first strobe is judged against the same window.
- R9: A tick comes every CLK_PER_TICK clock cycles. Each accepted strobe restarts the prescaler, so every window is measured to the clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_i | input | 1 | Asynchronous liveness strobe from the processor |
| irq_o | output | 1 | Fault interrupt, level-high while latched |
| disable_o | output | 1 | Output-stage disable, level-high while latched |
| cause_o | output | 2 | Fault cause: 00 none, 01 early, 10 late |

## Verification
The bench places strobes on the exact boundary cycles of the window. These are the last early cycle, the first valid cycle, and the final valid cycle, which is the one that coincides with the late timeout. An off-by-one in the compare or in the prescaler restart would trip or miss a fault one cycle away from where it should. A long low pulse followed by a rise probes edge polarity: a design that also counted rising edges would report an early fault in the middle of the interval. After each kind of fault, well-timed strobes and long idle stretches check that the latch and its first cause hold. A design that re-armed or overwrote the cause would drop the interrupt or flip the cause to late. Faults from the very first interval after reset, in both directions, confirm that reset release starts the first window.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_EARLY = 2'b01,
    CAUSE_LATE  = 2'b10
  } cause_e;
endpackage

// File: rtl/wdw_strobe_sync.sv
// Synchronizes the asynchronous strobe and reports its falling edges.
module wdw_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] stage_q;
  logic                   last_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= 1'b0;
          else     stage_q[0] <= strobe_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= 1'b0;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= stage_q[SYNC_STAGES-1];
  end

  // Falling edge: high one cycle ago, low now (R2).
  assign fall_o = last_q & ~stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/wdw_tick_gen.sv
// Prescaler: one tick every CLK_PER_TICK cycles, restartable (R9).
module wdw_tick_gen #(
  parameter int CLK_PER_TICK = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick_o
);
  localparam int CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run && !restart && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (run) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/wdw_interval.sv
// Counts ticks since the last accepted falling edge and judges the window.
module wdw_interval #(
  parameter int MIN_TICKS = 18,
  parameter int MAX_TICKS = 34,
  parameter int EW        = $clog2(MAX_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          fall,
  input  logic          tick,
  output logic [EW-1:0] elapsed_o,
  output logic          early_o,
  output logic          late_o
);
  localparam logic [EW-1:0] MIN_E  = EW'(MIN_TICKS);
  localparam logic [EW-1:0] LAST_E = EW'(MAX_TICKS - 1);

  logic [EW-1:0] elapsed_q;

  assign elapsed_o = elapsed_q;
  // Early: a falling edge before MIN full ticks (R3).
  assign early_o = run && fall && (elapsed_q < MIN_E);
  // Late: the tick that would complete MAX ticks, with no edge this cycle (R5).
  assign late_o  = run && !fall && tick && (elapsed_q == LAST_E);

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed_q <= '0;
    end else if (run) begin
      if (fall)      elapsed_q <= '0;
      else if (tick) elapsed_q <= elapsed_q + EW'(1);
    end
  end
endmodule

// File: rtl/wdw_fault_latch.sv
// Captures the first fault and its cause; only reset clears it (R6, R7).
module wdw_fault_latch
  import wdw_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   early,
  input  logic   late,
  output logic   failed_o,
  output logic   irq_o,
  output logic   disable_o,
  output cause_e cause_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      failed_o  <= 1'b0;
      irq_o     <= 1'b0;
      disable_o <= 1'b0;
      cause_o   <= CAUSE_NONE;
    end else if (!failed_o && (early || late)) begin
      failed_o  <= 1'b1;
      irq_o     <= 1'b1;
      disable_o <= 1'b1;
      cause_o   <= early ? CAUSE_EARLY : CAUSE_LATE;
    end
  end
endmodule

// File: rtl/strobe_window_guard.sv
module strobe_window_guard #(
  parameter int CLK_PER_TICK = 50000,
  parameter int MIN_TICKS    = 18,
  parameter int MAX_TICKS    = 34,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe_i,
  output logic       irq_o,
  output logic       disable_o,
  output logic [1:0] cause_o
);
  import wdw_pkg::*;

  localparam int EW = $clog2(MAX_TICKS + 1);

  logic          strobe_fall;
  logic          tick;
  logic          failed;
  logic          run;
  logic          early;
  logic          late;
  logic [EW-1:0] elapsed_ticks;
  cause_e        cause;

  // Timing freezes once a fault is latched (R6).
  assign run = ~failed;

  wdw_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (strobe_i),
    .fall_o   (strobe_fall)
  );

  wdw_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .restart (strobe_fall),
    .tick_o  (tick)
  );

  wdw_interval #(
    .MIN_TICKS (MIN_TICKS),
    .MAX_TICKS (MAX_TICKS),
    .EW        (EW)
  ) u_intv (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .fall      (strobe_fall),
    .tick      (tick),
    .elapsed_o (elapsed_ticks),
    .early_o   (early),
    .late_o    (late)
  );

  wdw_fault_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .early     (early),
    .late      (late),
    .failed_o  (failed),
    .irq_o     (irq_o),
    .disable_o (disable_o),
    .cause_o   (cause)
  );

  assign cause_o = cause;
endmodule

// File: rtl/wdw_checker.sv
module wdw_checker #(
  parameter int MIN_TICKS = 18,
  parameter int MAX_TICKS = 34,
  parameter int EW        = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          strobe_fall,
  input logic          tick,
  input logic [EW-1:0] elapsed_ticks,
  input logic          irq_o,
  input logic          disable_o,
  input logic [1:0]    cause_o
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!irq_o && !disable_o && cause_o == 2'b00));

  p_early_trip_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe_fall && !irq_o && elapsed_ticks < EW'(MIN_TICKS))
      |=> (irq_o && cause_o == 2'b01));

  p_valid_ok_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe_fall && !irq_o && elapsed_ticks >= EW'(MIN_TICKS)) |=> !irq_o);

  p_late_trip_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && !strobe_fall && !irq_o && elapsed_ticks == EW'(MAX_TICKS - 1))
      |=> (irq_o && cause_o == 2'b10));

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> (irq_o && $stable(cause_o)));

  p_outputs_agree_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_o == disable_o) && (irq_o == (cause_o != 2'b00)));

  p_elapsed_bound_r9: assert property (@(posedge clk) disable iff (rst)
    elapsed_ticks <= EW'(MAX_TICKS));
endmodule

bind strobe_window_guard wdw_checker #(
  .MIN_TICKS (MIN_TICKS),
  .MAX_TICKS (MAX_TICKS),
  .EW        (EW)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .strobe_fall   (strobe_fall),
  .tick          (tick),
  .elapsed_ticks (elapsed_ticks),
  .irq_o         (irq_o),
  .disable_o     (disable_o),
  .cause_o       (cause_o)
);

// File: tb/strobe_window_guard_tb.sv
module strobe_window_guard_tb;
  localparam int T    = 4;
  localparam int MINT = 5;
  localparam int MAXT = 9;
  localparam int LATE = MAXT * T;   // 36 cycles

  typedef struct {
    int         at;
    bit         irq;
    logic [1:0] cause;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe_i = 1'b1;
  logic       irq_o;
  logic       disable_o;
  logic [1:0] cause_o;

  int   cyc = 0;
  int   s = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  strobe_window_guard #(
    .CLK_PER_TICK (T),
    .MIN_TICKS    (MINT),
    .MAX_TICKS    (MAXT)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .strobe_i  (strobe_i),
    .irq_o     (irq_o),
    .disable_o (disable_o),
    .cause_o   (cause_o)
  );

  // Monitor: compares each expected item at the negedge following its edge.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.at != cyc) begin
        errors++;
        $display("FAIL %s: check for edge %0d missed (now %0d)", e.req, e.at, cyc);
      end else if (irq_o !== e.irq || disable_o !== e.irq || cause_o !== e.cause) begin
        errors++;
        $display("FAIL %s @%0d: irq=%b dis=%b cause=%b, expected irq=%b dis=%b cause=%b",
                 e.req, cyc, irq_o, disable_o, cause_o, e.irq, e.irq, e.cause);
      end
    end
  end

  task automatic expect_at(input int at, input bit irq, input logic [1:0] cause,
                           input string req);
    exp_t e;
    e.at = at; e.irq = irq; e.cause = cause; e.req = req;
    sb.push_back(e);
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    strobe_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    s = cyc;          // last reset edge starts the first interval (R8)
  endtask

  // Falling edge acted on at edge s+d; strobe stays low for 'low' cycles.
  task automatic strobe_at(input int d, input int low);
    int j;
    j = s + d - 3;
    wait_until(j);
    strobe_i = 1'b0;
    wait_until(j + low);
    strobe_i = 1'b1;
    s = j + 3;
  endtask

  initial begin
    int b;
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          errors++;
          $display("FAIL watchdog: run did not finish, expected completion");
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none

    // R1 reset state
    do_reset();
    expect_at(s + 1, 0, 2'b00, "R1");
    // R4 first valid cycle (d = MIN*T+1)
    expect_at(s + 21, 0, 2'b00, "R4");
    strobe_at(21, 3);
    // R5 final valid cycle coincides with the late timeout: strobe wins
    expect_at(s + LATE, 0, 2'b00, "R5");
    strobe_at(LATE, 3);
    // R9 restart: mid-window strobes keep the supervisor quiet
    expect_at(s + 25, 0, 2'b00, "R9");
    strobe_at(25, 3);
    expect_at(s + 30, 0, 2'b00, "R4");
    strobe_at(30, 3);
    // R3 last early cycle (d = MIN*T)
    expect_at(s + 19, 0, 2'b00, "R3");
    expect_at(s + 20, 1, 2'b01, "R3");
    strobe_at(20, 3);
    // R6 a well-timed strobe and a long idle stretch do not clear the fault
    b = s;
    expect_at(b + 30, 1, 2'b01, "R6");
    expect_at(b + LATE + 20, 1, 2'b01, "R6");
    strobe_at(25, 3);
    wait_until(b + LATE + 22);

    // R1 reset clears the latch; R8 late from reset release
    do_reset();
    expect_at(s + 1, 0, 2'b00, "R1");
    expect_at(s + LATE - 1, 0, 2'b00, "R8");
    expect_at(s + LATE, 1, 2'b10, "R8");
    wait_until(s + LATE + 3);

    // R8 early first strobe
    do_reset();
    expect_at(s + 10, 1, 2'b01, "R8");
    strobe_at(10, 3);
    wait_until(s + 3);

    // R2 a rising edge mid-interval is ignored
    do_reset();
    expect_at(s + 22, 0, 2'b00, "R2");
    strobe_at(22, 15);
    expect_at(s + 24, 0, 2'b00, "R2");
    strobe_at(24, 3);
    // R5 late after a valid interval, then R6 a late strobe keeps cause late
    b = s;
    expect_at(b + LATE - 1, 0, 2'b00, "R5");
    expect_at(b + LATE, 1, 2'b10, "R5");
    expect_at(b + LATE + 4, 1, 2'b10, "R6");
    strobe_at(LATE + 1, 3);
    wait_until(b + LATE + 6);

    // R7 checked on every item above (disable equals irq)
    wait_until(cyc + 2);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R7: %0d expected items left, expected 0", sb.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule